// File: doc/BRIEF.md
# Flash Command Sequencer

This block decodes command bytes written over a simple memory bus and runs the write-state operations of a NOR-style flash memory: word program, block erase, erase suspend and erase resume. A small internal register file stands in for the array. Program and erase times come from a down-counter whose lengths are parameters, so the sequencing can be tested without analog timing.

Every bus write is either a command byte (in the low eight bits of the write data) or the data/address phase of a two-write sequence. Bus reads are combinational and return either the addressed array word or the status byte, depending on the current read mode. While an operation is in flight only a small set of commands is accepted; all other writes are dropped.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After the active-low reset the block is in array-read mode, the array holds all-ones in every word, and the status byte reads 0x80. Status layout: bit 7 ready (1 = not busy), bit 6 erase suspended, bit 5 erase error, bit 4 program error, bits 3..0 zero.
- R2: Command 0x40 or 0x10 arms a program; the next write ANDs its data into the word at its address. The status ready bit returns to 1 exactly PROG_CYC cycles after that write, and reads then return the status byte.
- R3: If the write after a program arm is all-ones, the array is left unchanged, the block stays busy for PROG_CYC cycles and then reads return the status byte.
- R4: Command 0x20 followed by any write other than 0xD0 sets status bits 4 and 5, returns to ready in read-status mode and leaves the array unchanged.
- R5: 0x20 then 0xD0 sets every word of the block selected by the upper address bits (block size 2^BLK_AW words) to all-ones, ERASE_CYC cycles after the 0xD0 write. During the erase, reads return status with bit 7 at 0 and writes other than 0x70 and 0xB0 are ignored.
- R6: 0xB0 during an erase suspends it: status reads 0xC0 (ready and suspended) and the remaining cycle count is kept. While suspended, 0xFF selects array reads, 0x70 selects status reads, 0xD0 resumes and all other writes are ignored; the resumed erase finishes after the remaining cycles.
- R7: After 0x70 every read returns the status byte regardless of address.
- R8: 0xB0 written while idle selects array-read mode.
- R9: Command 0x50 clears status bits 4 and 5.
- R10: Asserting reset during an operation, suspended or not, aborts it at once: ready, not suspended, error bits clear, array-read mode.
- R11: During a program, every bus write is ignored and reads keep returning status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | AW | Word address for reads and writes |
| bus_wdata | input | DW | Write data; command byte in bits 7..0 |
| bus_rdata | output | DW | Read data: array word or zero-extended status byte |

## Verification
Directed sequences cover each command path: plain program with both setup codes, a program whose data write is all-ones, an erase setup followed by a non-confirm byte, a full erase, and an erase suspended after a fixed number of cycles and then resumed. The suspend case tells apart a counter that keeps its remaining count from one that restarts or keeps running, because the busy time after resume is measured exactly. Writes injected during program, erase and suspend distinguish a decoder that honours the restricted command set from one that accepts everything. A seeded random mix of programs on random words with random data and erases of random blocks, checked against a bench array model, separates correct AND-programming and block selection from overwriting or wrong block decoding.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG_ARM,
    ST_PROG_RUN,
    ST_PROG_VOID,
    ST_ERASE_ARM,
    ST_ERASE_RUN,
    ST_ERASE_HOLD
  } fsm_t;

  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [7:0] OP_PROG       = 8'h40;
  localparam logic [7:0] OP_PROG_ALT   = 8'h10;
  localparam logic [7:0] OP_ERASE      = 8'h20;
  localparam logic [7:0] OP_CONFIRM    = 8'hD0;
  localparam logic [7:0] OP_SUSPEND    = 8'hB0;
  localparam logic [7:0] OP_STATUS     = 8'h70;
  localparam logic [7:0] OP_CLEAR      = 8'h50;

endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = run && (cnt_q == CW'(1));

  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !run) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/flash_word_array.sv
module flash_word_array #(
  parameter int DW     = 8,
  parameter int AW     = 6,
  parameter int BLK_AW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prog_en,
  input  logic [AW-1:0]        prog_addr,
  input  logic [DW-1:0]        prog_data,
  input  logic                 erase_en,
  input  logic [AW-BLK_AW-1:0] erase_blk,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data
);

  localparam int WORDS = 1 << AW;

  logic [WORDS-1:0][DW-1:0] mem_flat;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [AW-1:0] W_IDX = AW'(w);
    logic [DW-1:0] word_q;
    logic          prog_hit;
    logic          erase_hit;

    assign prog_hit  = prog_en && (prog_addr == W_IDX);
    assign erase_hit = erase_en && (W_IDX[AW-1:BLK_AW] == erase_blk);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '1;
      end else if (erase_hit) begin
        word_q <= '1;
      end else if (prog_hit) begin
        word_q <= word_q & prog_data;
      end
    end

    assign mem_flat[w] = word_q;
  end

  assign rd_data = mem_flat[rd_addr];

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_en && erase_en)); // R5

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 6,
  parameter int BLK_AW    = 4,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);

  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BW   = AW - BLK_AW;

  fsm_t          st_q, st_d;
  logic          rds_q, rds_d;
  logic          perr_q, eerr_q;
  logic          perr_set, eerr_set, err_clr;
  logic          cap_en;
  logic [AW-1:0] op_addr_q;
  logic [DW-1:0] op_data_q;
  logic          tmr_load, tmr_run, tmr_done;
  logic [CW-1:0] tmr_len;
  logic          arr_prog, arr_erase;
  logic [DW-1:0] arr_rdata;
  logic [7:0]    cmd;
  logic [7:0]    status8;

  assign cmd     = bus_wdata[7:0];
  assign tmr_run = (st_q == ST_PROG_RUN) || (st_q == ST_PROG_VOID) ||
                   (st_q == ST_ERASE_RUN);

  always_comb begin
    st_d     = st_q;
    rds_d    = rds_q;
    perr_set = 1'b0;
    eerr_set = 1'b0;
    err_clr  = 1'b0;
    cap_en   = 1'b0;
    tmr_load = 1'b0;
    tmr_len  = CW'(PROG_CYC);
    arr_prog = 1'b0;
    arr_erase = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (bus_we) begin
          case (cmd)
            OP_READ_ARRAY: rds_d = 1'b0;
            OP_PROG, OP_PROG_ALT: begin
              st_d  = ST_PROG_ARM;
              rds_d = 1'b1;
            end
            OP_ERASE: begin
              st_d  = ST_ERASE_ARM;
              rds_d = 1'b1;
            end
            OP_STATUS:  rds_d   = 1'b1;
            OP_CLEAR:   err_clr = 1'b1;
            OP_SUSPEND: rds_d   = 1'b0;
            default: ;
          endcase
        end
      end
      ST_PROG_ARM: begin
        if (bus_we) begin
          tmr_load = 1'b1;
          tmr_len  = CW'(PROG_CYC);
          if (&bus_wdata) begin
            st_d = ST_PROG_VOID;
          end else begin
            cap_en = 1'b1;
            st_d   = ST_PROG_RUN;
          end
        end
      end
      ST_PROG_RUN: begin
        if (tmr_done) begin
          arr_prog = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      ST_PROG_VOID: begin
        if (tmr_done) begin
          st_d = ST_IDLE;
        end
      end
      ST_ERASE_ARM: begin
        if (bus_we) begin
          if (cmd == OP_CONFIRM) begin
            cap_en   = 1'b1;
            tmr_load = 1'b1;
            tmr_len  = CW'(ERASE_CYC);
            st_d     = ST_ERASE_RUN;
          end else begin
            perr_set = 1'b1;
            eerr_set = 1'b1;
            st_d     = ST_IDLE;
          end
        end
      end
      ST_ERASE_RUN: begin
        if (tmr_done) begin
          arr_erase = 1'b1;
          st_d      = ST_IDLE;
        end else if (bus_we && (cmd == OP_SUSPEND)) begin
          st_d = ST_ERASE_HOLD;
        end else if (bus_we && (cmd == OP_STATUS)) begin
          rds_d = 1'b1;
        end
      end
      ST_ERASE_HOLD: begin
        if (bus_we) begin
          case (cmd)
            OP_READ_ARRAY: rds_d = 1'b0;
            OP_STATUS:     rds_d = 1'b1;
            OP_CONFIRM: begin
              st_d  = ST_ERASE_RUN;
              rds_d = 1'b1;
            end
            default: ;
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rds_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rds_q <= rds_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_q <= 1'b0;
      eerr_q <= 1'b0;
    end else if (err_clr) begin
      perr_q <= 1'b0;
      eerr_q <= 1'b0;
    end else begin
      if (perr_set) perr_q <= 1'b1;
      if (eerr_set) eerr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr_q <= '0;
      op_data_q <= '0;
    end else if (cap_en) begin
      op_addr_q <= bus_addr;
      op_data_q <= bus_wdata;
    end
  end

  flash_op_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_len),
    .run      (tmr_run),
    .done     (tmr_done)
  );

  flash_word_array #(.DW(DW), .AW(AW), .BLK_AW(BLK_AW)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_en   (arr_prog),
    .prog_addr (op_addr_q),
    .prog_data (op_data_q),
    .erase_en  (arr_erase),
    .erase_blk (op_addr_q[AW-1:AW-BW]),
    .rd_addr   (bus_addr),
    .rd_data   (arr_rdata)
  );

  assign status8   = {!tmr_run, (st_q == ST_ERASE_HOLD), eerr_q, perr_q, 4'b0000};
  assign bus_rdata = rds_q ? DW'(status8) : arr_rdata;

  AST_SUSP_FROM_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ERASE_HOLD) && ($past(st_q) != ST_ERASE_HOLD)) |->
      ($past(st_q) == ST_ERASE_RUN)); // R6

  AST_STATUS_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st_q) == ST_PROG_RUN) && (st_q == ST_IDLE)) |-> rds_q); // R2

  AST_BUSY_SHOWS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ERASE_RUN) || (st_q == ST_PROG_RUN)) |-> (rds_q && !bus_rdata[7])); // R5

  AST_ERASE_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st_q) == ST_ERASE_ARM) && $past(bus_we) &&
     ($past(cmd) != OP_CONFIRM)) |-> (eerr_q && perr_q && rds_q)); // R4

  AST_IDLE_SUSPEND_READS_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st_q) == ST_IDLE) && $past(bus_we) && ($past(cmd) == OP_SUSPEND)) |->
      !rds_q); // R8

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb;

  localparam int DW = 8;
  localparam int AW = 6;
  localparam int BLK_AW = 4;
  localparam int PROG_CYC = 4;
  localparam int ERASE_CYC = 20;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mem_m [WORDS];
  bit m_perr, m_eerr;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.DW(DW), .AW(AW), .BLK_AW(BLK_AW), .PROG_CYC(PROG_CYC),
                   .ERASE_CYC(ERASE_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [7:0] st_exp(bit busy, bit susp, bit e, bit p);
    return {!busy, susp, e, p, 4'b0000};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_ready(output int n);
    logic [DW-1:0] v;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      rd(0, v);
      if (v[7]) break;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < WORDS; i++) mem_m[i] = 8'hFF;
    m_perr = 0; m_eerr = 0;
  endtask

  task automatic do_prog(logic [7:0] code, logic [AW-1:0] a, logic [7:0] d, bit chk_time);
    int n;
    logic [DW-1:0] v;
    wr(0, code);
    wr(a, d);
    wait_ready(n);
    if (chk_time) chk(n == PROG_CYC, "R2 program duration", n, PROG_CYC);
    mem_m[a] = mem_m[a] & d;
    rd(a, v);
    chk(v == st_exp(0, 0, m_eerr, m_perr), "R2 status after program", v, st_exp(0, 0, m_eerr, m_perr));
  endtask

  task automatic do_erase(logic [AW-1:0] a);
    int n;
    wr(0, 8'h20);
    wr(a, 8'hD0);
    wait_ready(n);
    chk(n == ERASE_CYC, "R5 erase duration", n, ERASE_CYC);
    for (int i = 0; i < WORDS; i++)
      if ((i >> BLK_AW) == (a >> BLK_AW)) mem_m[i] = 8'hFF;
  endtask

  task automatic cmp_word(logic [AW-1:0] a, string tag);
    logic [DW-1:0] v;
    wr(0, 8'hFF);
    rd(a, v);
    chk(v == mem_m[a], tag, v, mem_m[a]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    int n;
    int m;
    int unsigned seed;
    seed = $urandom(32'd7351);
    bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(6'h05, v);
    chk(v == 8'hFF, "R1 reset array read", v, 8'hFF);
    wr(6'h05, 8'h70);
    rd(6'h2A, v);
    chk(v == 8'h80, "R1 R7 reset status", v, 8'h80);

    // R2 program with both setup codes
    do_prog(8'h40, 6'h03, 8'hA5, 1);
    do_prog(8'h10, 6'h03, 8'h0F, 1);
    cmp_word(6'h03, "R2 AND program result");

    // R11 writes during program ignored
    wr(0, 8'h40);
    wr(6'h13, 8'h5A);
    wr(0, 8'hFF);
    wait_ready(n);
    mem_m[6'h13] = mem_m[6'h13] & 8'h5A;
    rd(6'h13, v);
    chk(v == 8'h80, "R11 write during program ignored", v, 8'h80);
    cmp_word(6'h13, "R11 program data");

    // R3 cancel
    wr(0, 8'h40);
    wr(6'h03, 8'hFF);
    wait_ready(n);
    chk(n == PROG_CYC, "R3 cancel duration", n, PROG_CYC);
    rd(6'h03, v);
    chk(v == 8'h80, "R3 status after cancel", v, 8'h80);
    cmp_word(6'h03, "R3 array unchanged");

    // R4 erase setup aborted, R9 clear
    wr(0, 8'h20);
    wr(6'h13, 8'h40);
    rd(6'h13, v);
    m_perr = 1; m_eerr = 1;
    chk(v == 8'hB0, "R4 abort status", v, 8'hB0);
    cmp_word(6'h13, "R4 array untouched");
    wr(0, 8'h50);
    wr(0, 8'h70);
    m_perr = 0; m_eerr = 0;
    rd(0, v);
    chk(v == 8'h80, "R9 clear error bits", v, 8'h80);

    // R5 erase block 1 with an ignored write inside
    wr(0, 8'h20);
    wr(6'h15, 8'hD0);
    wr(0, 8'hFF);
    rd(6'h13, v);
    chk(v[7:6] == 2'b00, "R5 busy status during erase", v, 8'h00);
    wait_ready(n);
    chk(n + 1 == ERASE_CYC, "R5 erase duration", n + 1, ERASE_CYC);
    for (int i = 16; i < 32; i++) mem_m[i] = 8'hFF;
    cmp_word(6'h13, "R5 erased word");
    cmp_word(6'h03, "R5 other block kept");

    // R6 suspend and resume
    do_prog(8'h40, 6'h23, 8'h3C, 1);
    wr(0, 8'h20);
    wr(6'h20, 8'hD0);
    m = 5;
    repeat (m) @(negedge clk);
    wr(0, 8'hB0);
    rd(0, v);
    chk(v == 8'hC0, "R6 suspended status", v, 8'hC0);
    wr(6'h23, 8'h40);
    rd(6'h23, v);
    chk(v == 8'hC0, "R6 program ignored while suspended", v, 8'hC0);
    wr(0, 8'hFF);
    rd(6'h23, v);
    chk(v == 8'h3C, "R6 array read while suspended", v, 8'h3C);
    wr(0, 8'h70);
    rd(6'h23, v);
    chk(v == 8'hC0, "R6 R7 status while suspended", v, 8'hC0);
    wr(0, 8'hD0);
    wait_ready(n);
    chk(n == ERASE_CYC - m - 1, "R6 remaining cycles after resume", n, ERASE_CYC - m - 1);
    for (int i = 32; i < 48; i++) mem_m[i] = 8'hFF;
    cmp_word(6'h23, "R6 erase completed");

    // R8 suspend when idle
    wr(0, 8'h70);
    wr(0, 8'hB0);
    rd(6'h03, v);
    chk(v == mem_m[6'h03], "R8 idle suspend reads array", v, mem_m[6'h03]);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int unsigned r;
      logic [AW-1:0] a;
      r = $urandom;
      a = AW'($urandom);
      if (r[1:0] == 2'b00) begin
        do_erase(a);
      end else begin
        do_prog(r[2] ? 8'h40 : 8'h10, a, 8'($urandom), 1);
      end
      cmp_word(AW'($urandom), "R2 R5 random array compare");
      cmp_word(a, "R2 R5 random target compare");
    end

    // R10 reset aborts a suspended erase
    wr(0, 8'h20);
    wr(0, 8'h00);
    wr(0, 8'h20);
    wr(6'h00, 8'hD0);
    repeat (3) @(negedge clk);
    wr(0, 8'hB0);
    rst_n = 0;
    model_reset();
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(6'h07, v);
    chk(v == 8'hFF, "R10 array read after reset", v, 8'hFF);
    wr(0, 8'h70);
    rd(0, v);
    chk(v == 8'h80, "R10 status after reset", v, 8'h80);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule